// File: doc/BRIEF.md
# Signed Serial-by-Parallel Multiplier

This block multiplies a two's-complement multiplicand, held in parallel registers, by a two's-complement operand that arrives one bit per clock. A row of identical cells, one per multiplicand bit, computes the product. Each cell talks only to the cell next to it. The only signal that reaches every cell is the incoming serial bit. The product leaves the row one bit per clock, least significant bit first.

The multiplicand is written with a load strobe while the block is idle. The source then sends the serial operand, least significant bit first, and marks its first bit with a frame strobe. After the operand's own bits, the source keeps repeating the operand's sign bit until the stream has lasted as many bits as the two operand widths together. The block answers one clock later with a serial stream of the same length, qualified by a valid strobe. That stream is the full-width signed product, so it cannot overflow. A new frame may start on the cycle right after the last input bit, which gives back-to-back products. A frame that arrives in the middle of a product abandons it and starts over.

Top module: `ser_par_smul`

## Requirements
- R1: When `load_i` is high on a cycle where no product is in progress and `frame_i` is low, `mcand_i` is stored as the signed multiplicand and used by every later product.
- R2: A `load_i` pulse that arrives while a product is in progress, or on the same cycle as `frame_i`, is ignored. The stored multiplicand, and so the product in progress and the products after it, stay unchanged.
- R3: The serial operand is taken on `serial_i` for MCAND_W+SER_W consecutive cycles, least significant bit first. `frame_i` is high only with bit 0. Bits SER_W and above are copies of the operand's sign bit.
- R4: Product bit k appears on `serial_o` in the cycle right after the cycle in which serial input bit k was applied. This is a one-clock latency, least significant bit first.
- R5: `valid_o` rises in the cycle after `frame_i` and stays high for exactly MCAND_W+SER_W consecutive cycles, unless another frame starts in that time.
- R6: The MCAND_W+SER_W output bits form the exact two's-complement product of the multiplicand and the serial operand. This includes the cases where either operand, or both, is at its most negative value.
- R7: A `frame_i` pulse during a product restarts the block. The output stream that follows is the product of the new operand alone, and `valid_o` stays high without a gap for MCAND_W+SER_W cycles after the new frame. A frame placed on the cycle after a stream's last bit gives two full products without a gap.
- R8: `serial_o` is 0 in every cycle where `valid_o` is 0. In particular, `serial_i` activity between frames does not show on `serial_o`.
- R9: After reset, `valid_o` and `serial_o` are 0 and the stored multiplicand is zero, so a product started before any load comes out as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Store `mcand_i` as the multiplicand (honoured only when idle) |
| mcand_i | input | MCAND_W | Signed multiplicand, parallel |
| frame_i | input | 1 | Marks bit 0 of a serial operand |
| serial_i | input | 1 | Serial operand bit, LSB first, sign-extended |
| serial_o | output | 1 | Product bit, LSB first |
| valid_o | output | 1 | Qualifies `serial_o` |

## Verification
The bench aims at the weighting of the sign bit. It multiplies the most negative multiplicand by the most negative operand, and mixes maximum positive values with maximum negative ones. A design that weighted the top multiplicand bit as positive would produce products off by a multiple of 2^(MCAND_W-1) times the operand. A design that left out the one-time correction would produce products off by exactly 2^(MCAND_W-1). Frames are aborted part way through and also sent back to back, so carries or sums left over from an earlier frame would corrupt the new product's low bits. A valid window one cycle too long or too short would show up as a wrong count of valid bits. Load pulses sent while a product is in progress and serial input toggling between frames check that neither one reaches the result.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef struct packed {
    logic c;
    logic s;
  } cell_st_t;

  function automatic int smul_len(input int a_w, input int b_w);
    return a_w + b_w;
  endfunction
endpackage

// File: rtl/smul_cell.sv
module smul_cell
  import smul_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic a_i,
  input  logic b_i,
  input  logic s_up_i,
  output logic s_o
);
  cell_st_t st_q, st_d;
  logic     x, s_eff, c_eff;
  logic [1:0] tot;

  always_comb begin
    // sign cell adds inverted term; the -2^(N-1) per-bit offset is
    // cancelled by presetting its carry at frame start
    x     = IS_TOP ? ~(a_i & b_i) : (a_i & b_i);
    s_eff = clr_i ? 1'b0 : s_up_i;
    c_eff = clr_i ? IS_TOP : st_q.c;
    tot   = {1'b0, x} + {1'b0, s_eff} + {1'b0, c_eff};
    st_d  = '{c: tot[1], s: tot[0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   st_q <= '0;
    else if (en_i) st_q <= st_d;
  end

  assign s_o = st_q.s;
endmodule

// File: rtl/smul_seq.sv
module smul_seq #(
  parameter int LEN = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic active_o,
  output logic busy_o,
  output logic valid_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          valid_q;

  assign busy_o   = (cnt_q != '0);
  assign active_o = frame_i | busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= active_o;
      if (frame_i)     cnt_q <= CW'(LEN - 1);
      else if (busy_o) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/ser_par_smul.sv
module ser_par_smul
  import smul_pkg::*;
#(
  parameter int MCAND_W = 8,
  parameter int SER_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [MCAND_W-1:0] mcand_i,
  input  logic               frame_i,
  input  logic               serial_i,
  output logic               serial_o,
  output logic               valid_o
);
  localparam int LEN = smul_len(MCAND_W, SER_W);

  logic [MCAND_W-1:0] mcand_q;
  logic [MCAND_W:0]   sum_w;
  logic               active, busy, valid_w;

  smul_seq #(.LEN(LEN)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_i),
    .active_o(active),
    .busy_o  (busy),
    .valid_o (valid_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mcand_q <= '0;
    else if (load_i && !busy && !frame_i) mcand_q <= mcand_i;
  end

  assign sum_w[MCAND_W] = 1'b0;

  for (genvar j = 0; j < MCAND_W; j++) begin : g_cell
    smul_cell #(.IS_TOP(j == MCAND_W - 1)) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (active),
      .clr_i (frame_i),
      .a_i   (mcand_q[j]),
      .b_i   (serial_i),
      .s_up_i(sum_w[j+1]),
      .s_o   (sum_w[j])
    );
  end

  assign valid_o  = valid_w;
  assign serial_o = valid_w & sum_w[0];
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int MCAND_W = 8,
  parameter int SER_W   = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic [MCAND_W-1:0] mcand_i,
  input logic               frame_i,
  input logic               serial_o,
  input logic               valid_o,
  input logic [MCAND_W-1:0] mcand_q,
  input logic               busy
);
  localparam int LEN = MCAND_W + SER_W;
  localparam int KW  = $clog2(LEN + 2);

  logic [KW-1:0] k_q;
  logic          win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       k_q <= '0;
    else if (frame_i)                  k_q <= KW'(1);
    else if (k_q != '0 && k_q <= KW'(LEN)) k_q <= k_q + 1'b1;
  end

  assign win = (k_q != '0) && (k_q <= KW'(LEN));

  a_r5_valid_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == win);

  a_r4_one_clock_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> valid_o);

  a_r8_quiet_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !serial_o);

  a_r2_mcand_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy || frame_i) |=> $stable(mcand_q));

  a_r1_load_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy && !frame_i) |=> (mcand_q == $past(mcand_i)));
endmodule

bind ser_par_smul smul_chk #(.MCAND_W(MCAND_W), .SER_W(SER_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .mcand_i (mcand_i),
  .frame_i (frame_i),
  .serial_o(serial_o),
  .valid_o (valid_o),
  .mcand_q (mcand_q),
  .busy    (busy)
);

// File: tb/tb_ser_par_smul.sv
module tb_ser_par_smul;
  localparam int N = 8;
  localparam int M = 6;
  localparam int L = N + M;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic [N-1:0] mcand_i = '0;
  logic         frame_i = 1'b0;
  logic         serial_i = 1'b0;
  logic         serial_o, valid_o;

  int           n_chk = 0, n_fail = 0;
  logic [L-1:0] got;
  int           vcnt;
  bit           done = 0;

  always #5 clk = ~clk;

  ser_par_smul #(.MCAND_W(N), .SER_W(M)) dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load_i), .mcand_i(mcand_i),
    .frame_i(frame_i), .serial_i(serial_i), .serial_o(serial_o), .valid_o(valid_o)
  );

  function automatic logic [L-1:0] prod(input logic [N-1:0] a, input logic [M-1:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    return p[L-1:0];
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // sample at negedge, shift valid bits in from the top (LSB arrives first)
  task automatic sample();
    if (valid_o) begin
      got = {serial_o, got[L-1:1]};
      vcnt++;
    end else if (serial_o !== 1'b0) begin
      check("R8 quiet output", serial_o, 0);
    end
  endtask

  task automatic do_load(input logic [N-1:0] a);
    @(negedge clk); sample();
    load_i = 1'b1; mcand_i = a; frame_i = 1'b0; serial_i = 1'($urandom);
  endtask

  task automatic feed(input logic [M-1:0] b, input int nbits, input int load_at,
                      input logic [N-1:0] junk);
    logic [L-1:0] bx;
    bx = {{(L-M){b[M-1]}}, b};
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); sample();
      frame_i  = (i == 0);
      serial_i = bx[i];
      load_i   = (i == load_at);
      mcand_i  = junk;
    end
  endtask

  task automatic drain(input logic [L-1:0] exp, input int exp_cnt, input string req);
    @(negedge clk); sample();
    frame_i = 1'b0; load_i = 1'b0; serial_i = 1'($urandom);
    @(negedge clk); sample();
    serial_i = 1'($urandom);
    check({req, " product"}, got, exp);
    check("R5 valid length", vcnt, exp_cnt);
    check("R5 valid falls", valid_o, 0);
  endtask

  task automatic one(input logic [N-1:0] a, input logic [M-1:0] b, input string req);
    do_load(a);
    vcnt = 0;
    feed(b, L, -1, '0);
    drain(prod(a, b), L, req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] a;
    logic [M-1:0] b, b2;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R9 reset valid", valid_o, 0);
    check("R9 reset serial", serial_o, 0);
    rst_n = 1'b1;

    // R9: no load yet, multiplicand is zero
    vcnt = 0;
    feed(6'h15, L, -1, '0);
    drain('0, L, "R9");

    // R4: first output bit one clock after the frame bit
    do_load(8'd3);
    vcnt = 0;
    @(negedge clk); sample();
    check("R4 valid before frame", valid_o, 0);
    load_i = 1'b0; frame_i = 1'b1; serial_i = 1'b1;
    @(negedge clk);
    check("R4 latency valid", valid_o, 1);
    check("R4 latency bit0", serial_o, 1);
    sample();
    frame_i = 1'b0; serial_i = 1'b0;
    for (int i = 2; i < L; i++) begin @(negedge clk); sample(); serial_i = 1'b0; end
    drain(prod(8'd3, 6'd1), L, "R4");

    // R6 directed sign corners
    one(8'h80, 6'h20, "R6 minneg*minneg");
    one(8'h80, 6'h1f, "R6 minneg*maxpos");
    one(8'h7f, 6'h20, "R6 maxpos*minneg");
    one(8'h7f, 6'h1f, "R6 maxpos*maxpos");
    one(8'hff, 6'h3f, "R6 -1*-1");
    one(8'h00, 6'h2a, "R6 zero");
    one(8'h01, 6'h20, "R1 one*minneg");

    // R2: load during busy and on frame cycle is ignored
    do_load(8'h9b);
    vcnt = 0;
    feed(6'h2d, L, 5, 8'h11);
    drain(prod(8'h9b, 6'h2d), L, "R2 mid-frame load");
    vcnt = 0;
    feed(6'h13, L, 0, 8'h22);
    drain(prod(8'h9b, 6'h13), L, "R2 frame-cycle load");

    // R7: abort and restart
    do_load(8'hc5);
    vcnt = 0;
    feed(6'h3a, 5, -1, '0);
    feed(6'h21, L, -1, '0);
    drain(prod(8'hc5, 6'h21), L + 5, "R7 abort");
    // R7: back-to-back
    vcnt = 0;
    feed(6'h0f, L, -1, '0);
    feed(6'h30, L, -1, '0);
    drain(prod(8'hc5, 6'h30), 2 * L, "R7 back-to-back");

    // R3/R6 random
    for (int t = 0; t < 300; t++) begin
      a = N'($urandom); b = M'($urandom);
      if (t % 3 == 0) begin
        b2 = M'($urandom);
        do_load(a);
        vcnt = 0;
        feed(b2, L, -1, '0);
        feed(b, L, -1, '0);
        drain(prod(a, b), 2 * L, "R3 random pair");
      end else begin
        one(a, b, "R6 random");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule